// File: doc/BRIEF.md
# Loop Bandwidth and Hitless-Switch Sequencer

This block decides, cycle by cycle, whether a clock-synthesis PLL runs with a wide or a narrow loop bandwidth, and whether its phase detector may drive the loop. It has two sources of control. The first is a power-up qualification. While initialization is enabled and narrow bandwidth is requested, the loop stays wide until it has shown a run of consecutive clean phase-detector cycles. The second is a hitless-switch sequence, which arms once the loop is locked. It reacts to a fresh loss of lock by switching the detector off for one cycle. During that cycle it may ask for a phase build-out step. It then holds narrow bandwidth while the loop re-qualifies lock, and it returns to wide bandwidth after a fixed timer runs out.

The lock monitor supplies two inputs: a loss-of-lock level and a strobe that marks each phase-detector comparison. The bandwidth and detector-enable outputs go to the analog loop. The build-out request goes to an edge-selection unit that sits outside this block.

Top module: `loop_bw_seq`

## Requirements
- R1: During and right after reset, `narrow_o` is 0, `pd_en_o` is 1 and `pbo_req_o` is 0.
- R2: While `init_i` is 0 and no hitless sequence is running, `narrow_o` is 0, whatever `nbw_req_i` is.
- R3: With `init_i`=1, a qualification is complete once LOCK_CNT (default 8) consecutive counted strobes have occurred. A strobe counts when `pd_cycle_i`=1 and `lol_i`=0 at a clock edge. `narrow_o` follows `nbw_req_i` from the cycle after the edge that completes this qualification. Before that, `narrow_o` is 0.
- R4: Any cycle with `lol_i`=1 resets the consecutive-strobe count to zero. A cycle with `pd_cycle_i`=0 and `lol_i`=0 neither adds to the count nor clears it.
- R5: The hitless function arms only when `hs_en_i`=1 and a lock qualification is complete. A rising `lol_i` that arrives before arming, or while `hs_en_i`=0, leaves `pd_en_o` at 1.
- R6: When armed, a rising edge of `lol_i` makes `pd_en_o` 0 and `narrow_o` 1 from the next cycle, for exactly one cycle. `pd_en_o` then returns to 1.
- R7: `pbo_req_o` is 1 in that detector-off cycle exactly when `pbo_en_i`=1, and it is 0 at all other times.
- R8: After the detector is re-enabled, `narrow_o` stays 1 while lock re-qualifies (R3 counting). It then stays 1 for TIMER_CYC further cycles (default 35, which is 175 ns at 200 MHz). After that, `narrow_o` returns to 0.
- R9: A cycle with `lol_i`=1 during the timer abandons the timer and restarts lock re-qualification, with `narrow_o` held at 1.
- R10: When the timer expires, the hitless function is re-armed, so a later rising `lol_i` starts the sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Power-up initialization enable; 0 forces wide bandwidth |
| nbw_req_i | input | 1 | Narrow bandwidth request |
| lol_i | input | 1 | Loss-of-lock level |
| pd_cycle_i | input | 1 | Strobe, one per phase-detector comparison |
| hs_en_i | input | 1 | Hitless-switch feature enable |
| pbo_en_i | input | 1 | Phase build-out step enable |
| narrow_o | output | 1 | 1 selects narrow loop bandwidth |
| pd_en_o | output | 1 | Phase detector enable |
| pbo_req_o | output | 1 | One-cycle phase build-out request |

## Verification
A wrong count in the lock qualifier moves the edge on which `narrow_o` rises or falls by the same number of cycles. The bench compares every cycle of each sweep against an arithmetic model, so such an error shows within one clock of the expected edge. A sequencer stuck in its detector-off state keeps `pd_en_o` low for more than one cycle, and this is visible on the second cycle. A lost re-arm shows only at the next loss-of-lock edge, as a `pd_en_o` that stays high. For that reason the bench fires a second event after the timer has expired.

// File: rtl/lbw_pkg.sv
package lbw_pkg;
  typedef enum logic [2:0] {
    HS_UNARMED = 3'd0,
    HS_ARMED   = 3'd1,
    HS_HOLD    = 3'd2,
    HS_RELOCK  = 3'd3,
    HS_TIMER   = 3'd4
  } hs_state_e;
endpackage

// File: rtl/lbw_lock_qual.sv
module lbw_lock_qual #(
  parameter int unsigned LOCK_CNT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic lol_i,
  input  logic pd_cycle_i,
  output logic qual_o
);
  localparam int unsigned W = $clog2(LOCK_CNT + 1);
  localparam logic [W-1:0] CNT_MAX = W'(LOCK_CNT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i || lol_i)         cnt_q <= '0;
    else if (pd_cycle_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o = (cnt_q == CNT_MAX);

  assert_lol_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lol_i |=> !qual_o);
  assert_cnt_bounded_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
  assert_idle_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pd_cycle_i && !lol_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/lbw_wbw_timer.sv
module lbw_wbw_timer #(
  parameter int unsigned TIMER_CYC = 35
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic en_i,
  output logic zero_o
);
  localparam int unsigned W = (TIMER_CYC < 2) ? 1 : $clog2(TIMER_CYC);
  localparam logic [W-1:0] LOAD_VAL = W'(TIMER_CYC - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= LOAD_VAL;
    else if (en_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  assert_tmr_bounded_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD_VAL);
  assert_tmr_moves_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && !zero_o) |=> !$stable(cnt_q));
endmodule

// File: rtl/lbw_hs_fsm.sv
module lbw_hs_fsm
  import lbw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hs_en_i,
  input  logic qual_i,
  input  logic lol_i,
  input  logic lol_rise_i,
  input  logic tmr_zero_i,
  output logic lq_clr_o,
  output logic tmr_load_o,
  output logic tmr_en_o,
  output logic hs_narrow_o,
  output logic hold_o
);
  hs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_UNARMED: if (hs_en_i && qual_i) state_d = HS_ARMED;
      HS_ARMED: begin
        if (!hs_en_i)        state_d = HS_UNARMED;
        else if (lol_rise_i) state_d = HS_HOLD;
      end
      HS_HOLD:   state_d = HS_RELOCK;
      HS_RELOCK: if (qual_i) state_d = HS_TIMER;
      HS_TIMER: begin
        if (lol_i)           state_d = HS_RELOCK;
        else if (tmr_zero_i) state_d = HS_ARMED;
      end
      default:   state_d = HS_UNARMED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= HS_UNARMED;
    else         state_q <= state_d;
  end

  assign hold_o      = (state_q == HS_HOLD);
  assign lq_clr_o    = hold_o;
  assign tmr_load_o  = (state_q == HS_RELOCK) && qual_i;
  assign tmr_en_o    = (state_q == HS_TIMER);
  assign hs_narrow_o = (state_q == HS_HOLD) || (state_q == HS_RELOCK) || (state_q == HS_TIMER);

  assert_hold_one_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == HS_HOLD) |=> (state_q == HS_RELOCK));
  assert_no_trig_disabled_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hs_en_i |=> (state_q != HS_HOLD));
  assert_timer_lol_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == HS_TIMER) && lol_i) |=> (state_q == HS_RELOCK));
  assert_rearm_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == HS_TIMER) && !lol_i && tmr_zero_i) |=> (state_q == HS_ARMED));
endmodule

// File: rtl/loop_bw_seq.sv
module loop_bw_seq
  import lbw_pkg::*;
#(
  parameter int unsigned LOCK_CNT  = 8,
  parameter int unsigned TIMER_CYC = 35
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic nbw_req_i,
  input  logic lol_i,
  input  logic pd_cycle_i,
  input  logic hs_en_i,
  input  logic pbo_en_i,
  output logic narrow_o,
  output logic pd_en_o,
  output logic pbo_req_o
);
  logic lol_q, init_done_q;
  logic qual, lq_clr, tmr_load, tmr_en, tmr_zero, hs_narrow, hold;
  logic lol_rise;

  assign lol_rise = lol_i & ~lol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lol_q       <= 1'b0;
      init_done_q <= 1'b0;
    end else begin
      lol_q <= lol_i;
      if (!init_i)   init_done_q <= 1'b0;
      else if (qual) init_done_q <= 1'b1;
    end
  end

  lbw_lock_qual #(.LOCK_CNT(LOCK_CNT)) u_lock_qual (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (lq_clr),
    .lol_i      (lol_i),
    .pd_cycle_i (pd_cycle_i),
    .qual_o     (qual)
  );

  lbw_wbw_timer #(.TIMER_CYC(TIMER_CYC)) u_wbw_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .en_i   (tmr_en),
    .zero_o (tmr_zero)
  );

  lbw_hs_fsm u_hs_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hs_en_i     (hs_en_i),
    .qual_i      (qual),
    .lol_i       (lol_i),
    .lol_rise_i  (lol_rise),
    .tmr_zero_i  (tmr_zero),
    .lq_clr_o    (lq_clr),
    .tmr_load_o  (tmr_load),
    .tmr_en_o    (tmr_en),
    .hs_narrow_o (hs_narrow),
    .hold_o      (hold)
  );

  assign narrow_o  = hs_narrow | (init_i & nbw_req_i & init_done_q);
  assign pd_en_o   = ~hold;
  assign pbo_req_o = hold & pbo_en_i;

  assert_pbo_in_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pbo_req_o |-> !pd_en_o);
  assert_pd_off_short_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_en_o |=> pd_en_o);
  assert_narrow_on_reenable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pd_en_o) |-> narrow_o);
  assert_pd_off_narrow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_en_o |-> narrow_o);
endmodule

// File: tb/loop_bw_seq_bench.sv
`timescale 1ns/1ps
module loop_bw_seq_bench;
  localparam int LOCK = 8;
  localparam int TCYC = 35;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic init_i = 0, nbw_req_i = 0, lol_i = 0, pd_cycle_i = 0, hs_en_i = 0, pbo_en_i = 0;
  logic narrow_o, pd_en_o, pbo_req_o;
  int errors = 0, checks = 0;

  always #2.5 clk_i = ~clk_i;

  loop_bw_seq #(.LOCK_CNT(LOCK), .TIMER_CYC(TCYC)) u_loop_bw_seq (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk_i); @(negedge clk_i); end
  endtask

  task automatic do_reset();
    rst_ni = 0; init_i = 0; nbw_req_i = 0; lol_i = 0; pd_cycle_i = 0;
    hs_en_i = 0; pbo_en_i = 0;
    cyc(2);
    rst_ni = 1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic ed;
    int s;
    @(negedge clk_i);
    do_reset();
    // R1 reset values
    chk("R1 narrow", narrow_o, 1'b0);
    chk("R1 pd_en", pd_en_o, 1'b1);
    chk("R1 pbo", pbo_req_o, 1'b0);
    cyc(1);
    chk("R1 narrow after release", narrow_o, 1'b0);

    // R2 init low forces wide
    nbw_req_i = 1; pd_cycle_i = 1;
    for (int j = 1; j <= 20; j++) begin cyc(1); chk("R2 init0 wide", narrow_o, 1'b0); end

    // R3 qualification with continuous strobes
    do_reset(); init_i = 1; nbw_req_i = 1; pd_cycle_i = 1;
    for (int j = 1; j <= 12; j++) begin
      cyc(1); chk("R3 qualify", narrow_o, j >= LOCK + 1);
    end
    nbw_req_i = 0; #1; chk("R3 nbw low wide", narrow_o, 1'b0);
    nbw_req_i = 1; #1; chk("R3 nbw high narrow", narrow_o, 1'b1);

    // R4 lol clears count
    do_reset(); init_i = 1; nbw_req_i = 1; pd_cycle_i = 1;
    cyc(LOCK - 1);
    lol_i = 1; cyc(1); lol_i = 0;
    for (int j = 1; j <= 12; j++) begin
      cyc(1); chk("R4 restart after lol", narrow_o, j >= LOCK + 1);
    end

    // R4 gapped strobes, model the count
    do_reset(); init_i = 1; nbw_req_i = 1;
    ed = 0; s = 0;
    for (int j = 0; j < 20; j++) begin
      pd_cycle_i = (j % 3 != 0);
      ed = ed | (s >= LOCK);
      if (pd_cycle_i && s < LOCK) s++;
      cyc(1);
      chk("R4 gapped strobes", narrow_o, ed);
    end

    // R5 no trigger when disabled or unarmed
    do_reset(); pd_cycle_i = 1; cyc(12);
    lol_i = 1; cyc(1); chk("R5 hs disabled pd_en", pd_en_o, 1'b1);
    lol_i = 0; cyc(1);
    hs_en_i = 1; lol_i = 1; cyc(1);
    chk("R5 unarmed pd_en", pd_en_o, 1'b1);
    chk("R5 unarmed narrow", narrow_o, 1'b0);
    lol_i = 0;

    // R6 R7 R8 sequence with build-out
    pbo_en_i = 1; cyc(12);
    chk("R5 armed idle pd_en", pd_en_o, 1'b1);
    lol_i = 1; cyc(1);
    chk("R6 pd off", pd_en_o, 1'b0);
    chk("R6 narrow forced", narrow_o, 1'b1);
    chk("R7 pbo pulse", pbo_req_o, 1'b1);
    lol_i = 0;
    for (int j = 1; j <= LOCK + 2 + TCYC + 2; j++) begin
      cyc(1);
      chk("R6 pd back on", pd_en_o, 1'b1);
      chk("R7 pbo low", pbo_req_o, 1'b0);
      chk("R8 narrow window", narrow_o, j < LOCK + 2 + TCYC);
    end

    // R10 re-arm, R7 without build-out, R9 lol during timer
    pbo_en_i = 0;
    lol_i = 1; cyc(1);
    chk("R10 retrigger pd off", pd_en_o, 1'b0);
    chk("R7 no pbo when disabled", pbo_req_o, 1'b0);
    lol_i = 0; cyc(1);
    cyc(LOCK + 2);
    chk("R9 in timer narrow", narrow_o, 1'b1);
    lol_i = 1; cyc(1); lol_i = 0;
    chk("R9 lol in timer narrow", narrow_o, 1'b1);
    for (int n = 1; n <= LOCK + 1 + TCYC + 2; n++) begin
      cyc(1);
      chk("R9 restarted window", narrow_o, n < LOCK + 1 + TCYC);
      chk("R9 pd on", pd_en_o, 1'b1);
    end

    finish_run();
  end
endmodule